// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock and tells the neighbouring shift engine when to act. A law-select bit picks how the divider value N is read. With the select at 0 the law is power-of-two: only the low exponent bits of N are used, and SCLK runs at the system rate divided by 2^(N+1). With the select at 1 the law is linear: all divider bits are used, and SCLK runs at the system rate divided by 2·(N+1). The fastest legal setting gives SCLK at half the system rate, so SCLK never runs faster than the system clock.

Polarity and phase are plain control inputs, and the polarity bit sets the idle level. The four SPI modes map to these bits as follows: mode 0 sets neither bit, mode 1 sets phase only, mode 2 sets polarity only, and mode 3 sets both. On each SCLK edge the block emits a one-cycle capture strobe or a one-cycle launch strobe, chosen by the phase setting. The shift register, the FIFOs and the register bus are outside this block. The block carries no data stream, so every pin is a plain level or strobe with no back-pressure.

Divider and law changes are applied only when a half period finishes, so SCLK never shows a shortened pulse. Polarity and phase are sampled only while the block is disabled.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `en` is low, `sclk` follows `cpol` one cycle later and neither strobe is asserted. Reset drives `sclk`, `launch` and `capture` low.
- R2: With `law`=0, every SCLK half period lasts 2^E system cycles, where E is `div_n[3:0]`. Bits of `div_n` above bit 3 have no effect. The first half period after `en` rises has the same length.
- R3: With `law`=1, every SCLK half period lasts `div_n`+1 system cycles, with `div_n` between 0 and 255.
- R4: With `law`=0 and E=0, SCLK toggles on every system clock, giving half the system rate. No setting toggles it faster.
- R5: Number the SCLK edges from 1, starting after `en` rises. With phase 0, odd edges carry `capture` and even edges carry `launch`. With phase 1 the roles swap. Each strobe is high for exactly the one cycle in which `sclk` first shows its new level.
- R6: Changes to `cpol` or `cpha` while `en` is high have no effect on SCLK or on the strobe pattern. They take effect only after `en` goes low.
- R7: A change of `div_n` or `law` while enabled leaves the half period in progress at its old length. Every later half period uses the new setting.
- R8: Dropping `en` mid-period returns `sclk` to idle on the next cycle. Re-enabling starts again at edge 1 after one full half period.
- R9: `launch` and `capture` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; low forces idle |
| law | input | 1 | Division law: 0 power-of-two, 1 linear |
| div_n | input | 8 | Divider value N |
| cpol | input | 1 | Clock polarity (idle level) |
| cpha | input | 1 | Clock phase: 0 capture on leading edge, 1 on trailing |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | One-cycle strobe: shift engine drives the next bit |
| capture | output | 1 | One-cycle strobe: shift engine samples the incoming bit |

## Verification
The bench measures the distance between successive SCLK edges in system cycles. It covers both laws, the fastest setting, and a power-of-two setting whose upper divider bits are set. A design that miscounted by one, or decoded the upper bits, would show a half period that is off.

It changes the divider and the law in the middle of a half period. A design that loaded the new value at once would shorten the current half and produce a runt pulse.

It flips polarity and phase while enabled. A design that sampled them there would swap the strobe roles mid-transfer or glitch SCLK.

It also disables and re-enables mid-period. A design that kept its edge parity or counter value across the gap would start on the wrong strobe or with a short first half.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             law,
  input  logic [DIV_W-1:0] div_n,
  input  logic             cpha,
  output logic [CNT_W-1:0] tc_q,
  output logic             pha_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  div_law_e         law_sel;
  logic [CNT_W-1:0] tc_nxt;

  // Terminal count = half period minus one.
  always_comb begin
    law_sel = div_law_e'(law);
    if (law_sel == LAW_POW2)
      tc_nxt = (ONE << div_n[EXP_W-1:0]) - ONE;
    else
      tc_nxt = CNT_W'(div_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= '0;
      pha_q <= 1'b0;
    end else begin
      if (!en || load) tc_q <= tc_nxt;
      if (!en) pha_q <= cpha;
    end
  end
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] tc,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = en && (cnt_q == tc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sclk_edge_steer.sv
module sclk_edge_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic cpol,
  input  logic pha,
  output logic sclk,
  output logic launch,
  output logic capture
);
  logic lead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk    <= 1'b0;
      lead_q  <= 1'b1;
      launch  <= 1'b0;
      capture <= 1'b0;
    end else if (!en) begin
      sclk    <= cpol;
      lead_q  <= 1'b1;
      launch  <= 1'b0;
      capture <= 1'b0;
    end else begin
      launch  <= 1'b0;
      capture <= 1'b0;
      if (tick) begin
        sclk   <= ~sclk;
        lead_q <= ~lead_q;
        if (lead_q ^ pha) capture <= 1'b1;
        else              launch  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             law,
  input  logic [DIV_W-1:0] div_n,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             launch,
  output logic             capture
);
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int CNT_W   = max_int(EXP_MAX + 1, DIV_W);

  logic [CNT_W-1:0] tc_q;
  logic             pha_q;
  logic             tick;

  sclk_cfg_latch #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en), .load(tick), .law(law),
    .div_n(div_n), .cpha(cpha), .tc_q(tc_q), .pha_q(pha_q)
  );

  sclk_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .tc(tc_q), .tick(tick)
  );

  sclk_edge_steer u_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cpol(cpol),
    .pha(pha_q), .sclk(sclk), .launch(launch), .capture(capture)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic sclk,
  input logic launch,
  input logic capture,
  input logic pha_q
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == $past(cpol)) && !launch && !capture);

  p_strobe_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch || capture) |-> (sclk != $past(sclk)));

  p_edge_has_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (sclk != $past(sclk))) |-> (launch || capture));

  p_capture_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(pha_q));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && capture));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .sclk(sclk),
  .launch(launch), .capture(capture), .pha_q(pha_q)
);

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       law = 1'b0;
  logic [7:0] div_n = '0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, launch, capture;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_sclk_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .law(law), .div_n(div_n),
    .cpol(cpol), .cpha(cpha), .sclk(sclk), .launch(launch), .capture(capture)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures n intervals from the current negedge; edge numbering starts at idx0.
  task automatic run_edges(input int half, input int n, input bit pha,
                           input int idx0, input string req);
    for (int k = 0; k < n; k++) begin
      int  cnt = 0;
      bit  stray = 0;
      logic prev = sclk;
      bit  lead, exp_cap;
      do begin
        @(negedge clk);
        cnt++;
        if (sclk === prev && (launch || capture)) stray = 1;
      end while (sclk === prev && cnt <= half + 4);
      check(cnt == half, req, cnt, half);
      lead    = ((idx0 + k) % 2) == 1;
      exp_cap = pha ? !lead : lead;
      check(capture === exp_cap && launch === !exp_cap && !stray, "R5",
            {30'd0, launch, capture}, {30'd0, !exp_cap, exp_cap});
    end
  endtask

  task automatic go_enable();
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic go_disable();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(sclk === 1'b0 && !launch && !capture, "R1 reset", sclk, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cpol  = 1'b1;
    @(negedge clk);
    check(sclk === 1'b1 && !launch && !capture, "R1 idle high", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    check(sclk === 1'b0, "R1 idle low", sclk, 0);
  endtask

  task automatic t_law_pow2();
    law = 1'b0; div_n = 8'd0;
    go_enable(); run_edges(1, 6, 0, 1, "R4 fastest"); go_disable();
    div_n = 8'd2;
    go_enable(); run_edges(4, 4, 0, 1, "R2 E=2"); go_disable();
    div_n = 8'hF2;
    go_enable(); run_edges(4, 4, 0, 1, "R2 upper bits ignored"); go_disable();
    div_n = 8'd5;
    go_enable(); run_edges(32, 3, 0, 1, "R2 E=5"); go_disable();
  endtask

  task automatic t_law_linear();
    law = 1'b1; div_n = 8'd0;
    go_enable(); run_edges(1, 4, 0, 1, "R3 N=0"); go_disable();
    div_n = 8'd4;
    go_enable(); run_edges(5, 4, 0, 1, "R3 N=4"); go_disable();
    div_n = 8'd9;
    go_enable(); run_edges(10, 3, 0, 1, "R3 N=9"); go_disable();
  endtask

  task automatic t_phase();
    law = 1'b1; div_n = 8'd1; cpol = 1'b1; cpha = 1'b1;
    @(negedge clk);
    check(sclk === 1'b1, "R1 idle cpol", sclk, 1);
    go_enable(); run_edges(2, 5, 1, 1, "R5 phase1"); go_disable();
    cpol = 1'b0; cpha = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_lock();
    law = 1'b1; div_n = 8'd2;
    go_enable();
    run_edges(3, 2, 0, 1, "R6 before");
    cpol = 1'b1; cpha = 1'b1;
    run_edges(3, 4, 0, 3, "R6 ignored while enabled");
    go_disable();
    check(sclk === 1'b1, "R6 new cpol after disable", sclk, 1);
    go_enable(); run_edges(3, 2, 1, 1, "R6 new cpha applied"); go_disable();
    cpol = 1'b0; cpha = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_retime();
    law = 1'b1; div_n = 8'd3;
    go_enable();
    run_edges(4, 1, 0, 1, "R7 start");
    div_n = 8'd1;
    run_edges(4, 1, 0, 2, "R7 half in progress kept");
    run_edges(2, 2, 0, 3, "R7 new divider");
    law = 1'b0; div_n = 8'd3;
    run_edges(2, 1, 0, 5, "R7 law change pending");
    run_edges(8, 2, 0, 6, "R7 new law");
    go_disable();
  endtask

  task automatic t_abort();
    law = 1'b1; div_n = 8'd5;
    go_enable();
    run_edges(6, 1, 0, 1, "R8 first");
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(sclk === 1'b0 && !launch && !capture, "R8 back to idle", sclk, 0);
    go_enable();
    run_edges(6, 2, 0, 1, "R8 restart");
    go_disable();
  endtask

  initial begin
    #(10 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_law_pow2();
    t_law_linear();
    t_phase();
    t_lock();
    t_retime();
    t_abort();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule